// File: doc/BRIEF.md
# Infrared Return-to-Zero Transmit Pulse Shaper

This block sits between a UART transmitter and an infrared LED driver. It takes the transmitter's NRZ serial stream and a one-cycle strobe that marks the start of every bit. For each zero bit it produces a short high pulse. One bits leave the output low. The pulse width is programmable and is counted in half periods of one of two clocks. One clock is a 16x oversampling bit clock and the other is the baud-rate source clock. Both arrive as single-cycle enables that already run at twice the clock rate, so each enable marks one half period. All logic runs on one edge of the system clock.

A pulse-length value of N gives N+1 half periods. With the 16x clock and N = 5, the pulse lasts 6 half periods, which is 3/16 of a bit. When the baud-rate source clock is chosen, the baud prescaler outside this block has to be 5 or more so that the pulse fits inside the bit. If the programmed pulse is still running when the next bit starts, the new bit's strobe cuts it short. When the encoder is off, the NRZ stream passes straight through.

Top module: `irda_tx_encoder`

## Requirements
- R1: While `enc_en` is 0, `ir_out` equals `tx_nrz` in the same cycle, with no register in the path. Strobes and ticks have no effect on it.
- R2: While enabled, a `bit_start` with `tx_nrz` = 0 makes `ir_out` go to 1 from the cycle after the strobe.
- R3: While enabled, a `bit_start` with `tx_nrz` = 1 produces no pulse, and `ir_out` is 0 from the cycle after the strobe.
- R4: A pulse ends on the clock edge where the (`pulse_len`+1)-th selected half-period tick after its strobe is sampled. A tick in the strobe cycle itself is not counted.
- R5: `clk_sel` = 1 selects `os_half_tick` (16x bit clock) and `clk_sel` = 0 selects `br_half_tick` (baud source clock). Ticks on the unselected input do not change the pulse width.
- R6: A `bit_start` during a pulse truncates it. A one bit ends it at that edge. A zero bit restarts the count, so `ir_out` stays high without a gap.
- R7: While enabled, `ir_out` is 0 between pulses and never rises except after a zero-bit strobe.
- R8: Clearing `enc_en` discards any pulse in progress. After re-enabling with no strobe, `ir_out` is 0.
- R9: Synchronous active-high `rst` clears the pulse state, so `ir_out` is 0 after reset while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | 1: shape pulses, 0: pass NRZ through |
| clk_sel | input | 1 | Half-period source: 1 oversampling clock, 0 baud source clock |
| os_half_tick | input | 1 | One-cycle enable per half period of the 16x bit clock |
| br_half_tick | input | 1 | One-cycle enable per half period of the baud source clock |
| bit_start | input | 1 | One-cycle strobe at the start of each transmitted bit |
| tx_nrz | input | 1 | NRZ transmit bit from the UART |
| pulse_len | input | LEN_W | Pulse width in half periods, minus one |
| ir_out | output | 1 | Shaped infrared drive signal |

## Verification
The in-RTL assertions check several rules on every cycle:
- a zero-bit strobe starts a pulse;
- a one-bit strobe leaves the output inactive;
- a rise of the pulse always follows a zero-bit strobe;
- turning the encoder off clears the pulse;
- a cycle with no selected tick and no strobe keeps the counter and the pulse unchanged.

Exact widths can only be shown by the bench's scenarios. These cover both clock sources with noise on the unselected tick, a pulse that exactly fills its bit, and truncation by a following one bit. They also cover back-to-back truncated zeros that merge into one long pulse, and the passthrough and disable-clearing behaviour.

// File: rtl/irda_tx_pkg.sv
package irda_tx_pkg;

    localparam int LEN_W_DEFAULT = 6;

    typedef enum logic {
        SRC_BAUD = 1'b0,
        SRC_OVS  = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic start;
        logic zero_bit;
        logic tick;
    } bit_evt_t;

    function automatic logic wants_pulse(input logic nrz);
        return ~nrz;
    endfunction

endpackage

// File: rtl/irda_tick_sel.sv
module irda_tick_sel
    import irda_tx_pkg::*;
(
    input  logic     os_half_tick,
    input  logic     br_half_tick,
    input  clk_src_e src,
    output logic     half_tick
);
    always_comb begin
        unique case (src)
            SRC_OVS:  half_tick = os_half_tick;
            default:  half_tick = br_half_tick;
        endcase
    end
endmodule

// File: rtl/irda_pulse_gen.sv
module irda_pulse_gen
    import irda_tx_pkg::*;
#(
    parameter int LEN_W = LEN_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  bit_evt_t         evt,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (evt.start) begin
            active <= evt.zero_bit;
            cnt    <= '0;
        end else if (active && evt.tick) begin
            if (cnt == len) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: zero-bit strobe starts a pulse
    a_r2_zero_starts: assert property (@(posedge clk) disable iff (rst)
        (enable && evt.start && evt.zero_bit) |=> active);

    // R3 / R6: one-bit strobe leaves or forces output inactive
    a_r3_one_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable && evt.start && !evt.zero_bit) |=> !active);

    // R7: any rise follows a zero-bit strobe
    a_r7_rise_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(enable && evt.start && evt.zero_bit));

    // R8: disable clears the pulse
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !active);

    // R5: without a selected tick or strobe, state holds
    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && active && !evt.tick && !evt.start)
        |=> (active && $stable(cnt)));
endmodule

// File: rtl/irda_tx_encoder.sv
module irda_tx_encoder
    import irda_tx_pkg::*;
#(
    parameter int LEN_W = LEN_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_en,
    input  logic             clk_sel,
    input  logic             os_half_tick,
    input  logic             br_half_tick,
    input  logic             bit_start,
    input  logic             tx_nrz,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             ir_out
);
    logic     sel_tick;
    logic     pulse_on;
    bit_evt_t evt;

    irda_tick_sel u_tick_sel (
        .os_half_tick (os_half_tick),
        .br_half_tick (br_half_tick),
        .src          (clk_src_e'(clk_sel)),
        .half_tick    (sel_tick)
    );

    always_comb begin
        evt.start    = bit_start;
        evt.zero_bit = wants_pulse(tx_nrz);
        evt.tick     = sel_tick;
    end

    irda_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .enable (enc_en),
        .evt    (evt),
        .len    (pulse_len),
        .active (pulse_on)
    );

    // R1 passthrough when disabled
    assign ir_out = enc_en ? pulse_on : tx_nrz;
endmodule

// File: tb/tb_irda_tx_encoder.sv
module tb_irda_tx_encoder;
    localparam int LEN_W = 6;

    logic clk = 1'b0;
    logic rst, enc_en, clk_sel, os_half_tick, br_half_tick, bit_start, tx_nrz;
    logic [LEN_W-1:0] pulse_len;
    logic ir_out;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    bit mon_en = 1'b0;
    int run_len = 0;

    always #10 clk = ~clk;

    irda_tx_encoder #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .enc_en(enc_en), .clk_sel(clk_sel),
        .os_half_tick(os_half_tick), .br_half_tick(br_half_tick),
        .bit_start(bit_start), .tx_nrz(tx_nrz), .pulse_len(pulse_len),
        .ir_out(ir_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ir_out actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: measure pulse widths, compare with scoreboard queue
    initial begin
        forever begin
            @(posedge clk); #2;
            if (mon_en) begin
                if (ir_out === 1'b1) run_len++;
                else if (run_len > 0) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R7 unexpected pulse actual %0d expected none", run_len);
                    end else begin
                        int e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (e != run_len) begin
                            errors++;
                            $display("FAIL %s pulse width actual %0d expected %0d", t, run_len, e);
                        end
                    end
                    run_len = 0;
                end
            end
        end
    end

    task automatic send_bit(input logic b, input int len, input int per,
                            input int blen, input logic sel);
        for (int c = 0; c < blen; c++) begin
            @(negedge clk);
            tx_nrz    = b;
            pulse_len = LEN_W'(len);
            clk_sel   = sel;
            bit_start = (c == 0);
            if (sel) begin
                os_half_tick = (c > 0) && (c % per == 0);
                br_half_tick = 1'b1;      // noise on unselected source
            end else begin
                br_half_tick = (c > 0) && (c % per == 0);
                os_half_tick = 1'b1;
            end
        end
    endtask

    task automatic expect_w(input int w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst = 1'b1; enc_en = 1'b1; clk_sel = 1'b1; os_half_tick = 1'b0;
        br_half_tick = 1'b0; bit_start = 1'b0; tx_nrz = 1'b1; pulse_len = '0;
        repeat (3) @(posedge clk);
        #2; check("R9 reset", ir_out, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1 passthrough
        enc_en = 1'b0; tx_nrz = 1'b0; bit_start = 1'b1;
        #1; check("R1 pass zero", ir_out, 1'b0);
        @(negedge clk); tx_nrz = 1'b1; bit_start = 1'b0;
        #1; check("R1 pass one", ir_out, 1'b1);
        @(negedge clk); tx_nrz = 1'b0;
        #1; check("R1 pass after strobe", ir_out, 1'b0);
        @(negedge clk); tx_nrz = 1'b1; enc_en = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R2/R4/R5 oversampling clock, 3/16 bit pulse
        expect_w(12, "R4 os len5");
        send_bit(1'b0, 5, 2, 32, 1'b1);
        send_bit(1'b1, 5, 2, 32, 1'b1);
        #1; check("R3 one bit quiet", ir_out, 1'b0);

        // R5 baud source clock
        expect_w(9, "R5 baud len2");
        send_bit(1'b0, 2, 3, 16, 1'b0);
        send_bit(1'b1, 2, 3, 16, 1'b0);

        // R6 truncation by a one bit
        expect_w(20, "R6 truncate by one");
        send_bit(1'b0, 15, 4, 20, 1'b1);
        send_bit(1'b1, 15, 4, 20, 1'b1);

        // R6 zero after zero restarts, merged pulse
        expect_w(40, "R6 zero restart");
        send_bit(1'b0, 15, 4, 20, 1'b0);
        send_bit(1'b0, 15, 4, 20, 1'b0);
        send_bit(1'b1, 15, 4, 20, 1'b0);

        // R4 minimum length
        expect_w(5, "R4 len0");
        send_bit(1'b0, 0, 5, 16, 1'b1);
        send_bit(1'b1, 0, 5, 16, 1'b1);

        // R4 exact fit
        expect_w(16, "R4 exact fit");
        send_bit(1'b0, 3, 4, 16, 1'b1);
        send_bit(1'b1, 3, 4, 16, 1'b1);

        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing pulses actual %0d expected 0", exp_q.size());
        end
        mon_en = 1'b0;

        // R8 disable clears pulse in progress
        @(negedge clk);
        tx_nrz = 1'b0; bit_start = 1'b1; pulse_len = 6'd40; clk_sel = 1'b1;
        os_half_tick = 1'b0; br_half_tick = 1'b0;
        @(negedge clk); bit_start = 1'b0; tx_nrz = 1'b1;
        #1; check("R2 pulse running", ir_out, 1'b1);
        @(negedge clk); enc_en = 1'b0;
        #1; check("R1 bypass while off", ir_out, 1'b1);
        @(negedge clk); enc_en = 1'b1;
        @(posedge clk); #2;
        check("R8 cleared after re-enable", ir_out, 1'b0);
        repeat (2) @(posedge clk); #2;
        check("R7 idle low", ir_out, 1'b0);

        report();
    end
endmodule